// File: doc/BRIEF.md
# Wide-to-narrow FIFO read adapter

This block sits on the read side of a FIFO that stores 36-bit words and drives an 18-bit output port. Each stored word leaves the block as two 18-bit halves or as four 9-bit bytes. A size select picks between the two. An order select sends the pieces either most significant first or least significant first. Both selects are captured while the master reset is low, and the captured values hold until the next reset.

The FIFO is assumed to be a dual-clock FIFO with a fall-through read side. Its read port runs in the output clock domain, so the output clock may be unrelated to the FIFO's write clock, and the adapter itself has only one clock. When the adapter holds no part of a word, the first piece of the FIFO's head word appears on the output at once. The adapter asserts the FIFO read strobe in the cycle that consumes that first piece. It then keeps the rest of the word in a holding register and pulls nothing more from the FIFO until the last piece of that word has been read.

Top module: `bus_match_unpacker`

## Requirements
- R1: While reset is low and the FIFO is empty, `out_empty` is 1 and `fifo_rd` is 0.
- R2: In word mode (`cfg_byte`=0) with `cfg_little`=0, a word W is read as W[35:18] and then W[17:0].
- R3: In word mode with `cfg_little`=1, a word W is read as W[17:0] and then W[35:18].
- R4: In byte mode (`cfg_byte`=1) with `cfg_little`=0, the order is W[35:27], W[26:18], W[17:9], W[8:0]. Each byte appears on `out_data[8:0]`, and `out_data[17:9]` is 0.
- R5: In byte mode with `cfg_little`=1, the order is W[8:0], W[17:9], W[26:18], W[35:27], with the same placement on the bus and `out_data[17:9]` at 0.
- R6: `fifo_rd` is 1 only in a cycle where `out_ren` is 1, no partial word is held and the FIFO is not empty, which is the cycle that consumes a word's first piece. It stays 0 while later pieces of that word remain.
- R7: `out_empty` is 0 whenever a partial word is held or the FIFO is not empty. With no partial word held, the first piece of the FIFO head word is on `out_data` in the same cycle.
- R8: `out_ren` while `out_empty` is 1 has no effect: `fifo_rd` stays 0, and the next word read starts with its first piece.
- R9: `cfg_byte` and `cfg_little` are sampled only while `rst_n` is 0. Changing them after reset does not alter the size or the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-side clock |
| rst_n | input | 1 | Active-low master reset; configuration is sampled while low |
| cfg_byte | input | 1 | 1 selects 9-bit pieces, 0 selects 18-bit pieces |
| cfg_little | input | 1 | 1 sends the least significant piece first |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_data | input | 36 | FIFO head word (fall-through) |
| fifo_rd | output | 1 | Pops the FIFO head word |
| out_ren | input | 1 | Output read enable |
| out_data | output | 18 | Current output piece |
| out_empty | output | 1 | No piece available |

## Verification
The assertions assume a fall-through FIFO: `fifo_data` holds the head word whenever `fifo_empty` is 0, and the head changes only after a `fifo_rd` pop or a push into an empty FIFO. The bench models the FIFO as a queue that keeps exactly this contract. It pops the queue only after the clock edge that sampled `fifo_rd`, and it pushes only between cycles. Configuration pins are changed after reset on purpose, which is allowed because the design ignores them then.

// File: rtl/bus_match_unpacker.sv
module bus_match_unpacker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_byte,
  input  logic        cfg_little,
  input  logic        fifo_empty,
  input  logic [35:0] fifo_data,
  output logic        fifo_rd,
  input  logic        out_ren,
  output logic [17:0] out_data,
  output logic        out_empty
);
  logic        mode_byte, mode_le, held, take;
  logic [1:0]  idx, last, pos;
  logic [35:0] word, cur;

  assign last      = mode_byte ? 2'd3 : 2'd1;
  assign cur       = held ? word : fifo_data;
  assign pos       = mode_le ? idx : 2'(last - idx);
  assign out_empty = !held && fifo_empty;
  assign take      = out_ren && !out_empty;
  assign fifo_rd   = take && !held;

  always_comb begin
    out_data = '0;
    if (mode_byte) begin
      case (pos)
        2'd0:    out_data[8:0] = cur[8:0];
        2'd1:    out_data[8:0] = cur[17:9];
        2'd2:    out_data[8:0] = cur[26:18];
        default: out_data[8:0] = cur[35:27];
      endcase
    end else begin
      out_data = pos[0] ? cur[35:18] : cur[17:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_byte <= cfg_byte;
      mode_le   <= cfg_little;
      held      <= 1'b0;
      idx       <= 2'd0;
      word      <= '0;
    end else if (take) begin
      if (idx == last) begin
        idx  <= 2'd0;
        held <= 1'b0;
      end else begin
        idx  <= idx + 2'd1;
        held <= 1'b1;
        if (!held) word <= fifo_data;
      end
    end
  end

  p_rd_needs_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);
  p_no_rd_mid_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !fifo_rd);
  p_hold_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !(out_ren && idx == last)) |=> (held && $stable(word)));
  p_empty_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_empty && out_ren) |=> (!held && idx == 2'd0));
  p_not_empty_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !out_empty);
  p_cfg_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(mode_byte) && $stable(mode_le)));
  p_byte_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_byte && !out_empty) |-> out_data[17:9] == 9'd0);
endmodule

// File: tb/bus_match_unpacker_test.sv
module bus_match_unpacker_test;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0, cfg_byte = 0, cfg_little = 0;
  logic        fifo_empty = 1, fifo_rd, out_ren = 0, out_empty;
  logic [35:0] fifo_data = '0;
  logic [17:0] out_data;

  logic [35:0] fq[$];
  logic [17:0] exp_q[$];
  int errors = 0, checks = 0, piece = 0, npieces = 2;
  bit m_byte = 0, m_le = 0;
  string tag = "R1";

  bus_match_unpacker uut (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string t, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic refresh();
    fifo_empty = (fq.size() == 0);
    fifo_data  = fifo_empty ? 36'd0 : fq[0];
  endtask

  task automatic push(logic [35:0] w);
    fq.push_back(w);
    for (int k = 0; k < npieces; k++) begin
      int s;
      s = m_le ? k : npieces - 1 - k;
      if (m_byte) exp_q.push_back({9'd0, w[s*9 +: 9]});
      else        exp_q.push_back(w[s*18 +: 18]);
    end
    refresh();
  endtask

  task automatic do_reset(bit b, bit le);
    rst_n = 0; cfg_byte = b; cfg_little = le;
    m_byte = b; m_le = le; npieces = b ? 4 : 2; piece = 0;
    fq.delete(); exp_q.delete(); refresh();
    out_ren = 0;
    repeat (2) @(posedge clk);
    #1;
    chk(out_empty == 1'b1, "R1", {35'd0, out_empty}, 36'd1);
    chk(fifo_rd == 1'b0, "R1", {35'd0, fifo_rd}, 36'd0);
    @(negedge clk); rst_n = 1;
  endtask

  // one cycle: drive, monitor and compare, then pop the FIFO model after the edge
  task automatic cycle(bit ren);
    bit pop;
    @(negedge clk);
    out_ren = ren;
    #1;
    if (ren && !out_empty) begin
      if (exp_q.size() == 0)
        chk(0, tag, {18'd0, out_data}, 36'd0);
      else begin
        logic [17:0] e;
        e = exp_q.pop_front();
        chk(out_data == e, tag, {18'd0, out_data}, {18'd0, e});
      end
      chk(fifo_rd == (piece == 0), "R6", {35'd0, fifo_rd}, {35'd0, piece == 0});
      piece = (piece + 1) % npieces;
    end else begin
      chk(fifo_rd == 1'b0, ren ? "R8" : "R6", {35'd0, fifo_rd}, 36'd0);
    end
    pop = fifo_rd;
    @(posedge clk); #1;
    if (pop && fq.size() != 0) void'(fq.pop_front());
    refresh();
  endtask

  task automatic scenario(bit b, bit le, string t, int nwords);
    do_reset(b, le);
    tag = t;
    for (int i = 0; i < nwords; i++) push({$urandom, 4'($urandom)});
    #1;
    chk(out_empty == 1'b0, "R7", {35'd0, out_empty}, 36'd0);
    for (int i = 0; i < nwords * 8; i++) cycle(($urandom % 4) != 0);
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) cycle(1);
    chk(exp_q.size() == 0, t, exp_q.size(), 0);
  endtask

  initial begin
    scenario(0, 0, "R2", 12);
    scenario(0, 1, "R3", 12);
    scenario(1, 0, "R4", 12);
    scenario(1, 1, "R5", 12);

    // R7: a partial word stays visible after the FIFO drains
    do_reset(1, 0); tag = "R4";
    push(36'h1_2345_6789);
    cycle(1);
    chk(out_empty == 1'b0, "R7", {35'd0, out_empty}, 36'd0);
    for (int i = 0; i < 3; i++) cycle(1);
    chk(out_empty == 1'b1, "R7", {35'd0, out_empty}, 36'd1);

    // R8: reads while empty are ignored, the next word starts at its first piece
    do_reset(0, 0); tag = "R8";
    for (int i = 0; i < 3; i++) begin
      cycle(1);
      chk(out_empty == 1'b1, "R8", {35'd0, out_empty}, 36'd1);
    end
    push(36'hA_BCDE_F012);
    for (int i = 0; i < 4; i++) cycle(1);
    chk(exp_q.size() == 0, "R8", exp_q.size(), 0);

    // R9: configuration pins changed after reset do not matter
    do_reset(0, 0); tag = "R9";
    cfg_byte = 1; cfg_little = 1;
    for (int i = 0; i < 6; i++) push({$urandom, 4'($urandom)});
    for (int i = 0; i < 30; i++) cycle(1);
    chk(exp_q.size() == 0, "R9", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule